// File: doc/BRIEF.md
# Three-by-three matrix multiplier

This block computes three weighted sums of a three-component sample, as needed for colour space conversion or a 3-D coordinate transform. On every clock a new triple of 12-bit signed samples (A, B, C) is accepted. Each output X, Y and Z is a dot product of that triple with one row of a 3x3 coefficient matrix. The full-precision result is rounded back to a 12-bit signed integer, so the data format is the same at the input and at the output.

The nine 10-bit signed fractional coefficients sit in onboard registers. A whole row of three is written per clock through three coefficient ports, so the full matrix can be replaced in three cycles. Sample streaming does not stop while this happens. The pipeline has a fixed depth and a valid flag that travels alongside the data. Results that overflow the 12-bit range wrap; they are not clamped.

Top module: `matmul3x3`

## Requirements
- R1: While rst_n is low and after it is released, out_valid is 0, x, y and z are 0, and all nine coefficient registers hold 0. Samples streamed before any coefficient write therefore give outputs of 0.
- R2: X is the dot product of (A, B, C) with coefficient row 0, Y uses row 1 and Z uses row 2. In every row, the coefficient written from ka multiplies A, the one from kb multiplies B and the one from kc multiplies C.
- R3: Samples are 12-bit two's complement integers. Coefficients are 10-bit two's complement values with 9 fraction bits, so a code k stands for k/512 and the range runs from -1 to 511/512.
- R4: The output is floor((S + 256) / 512), where S is the exact integer sum of the three sample-by-code products. This rounds half an LSB upward: 0.5 gives 1, -0.5 gives 0, 1.5 gives 2 and -1.0 gives -1. A zero sum gives a zero output.
- R5: Only the low 12 bits of the rounded result are output, with no saturation. For example, 2047 on every input with code 511 everywhere gives 2033, and -2048 with code 511 gives 2060.
- R6: On a rising edge with k_load high and k_row equal to 0, 1 or 2, the words on ka, kb and kc are written into that row. Three consecutive writes replace the whole matrix while samples keep streaming.
- R7: k_row equal to 3 with k_load high changes no coefficient. With k_load low, no coefficient changes whatever ka, kb and kc carry.
- R8: A sample captured on rising edge n shows up on x, y and z, with out_valid high, right after edge n+3.
- R9: A new sample is accepted on every edge. out_valid is in_valid delayed by four edges, and back-to-back samples come out back-to-back.
- R10: A coefficient written on the same edge that captures a sample already applies to that sample. Samples captured on earlier edges use the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a, b, c as a valid sample |
| a | input | 12 | First sample component, signed |
| b | input | 12 | Second sample component, signed |
| c | input | 12 | Third sample component, signed |
| k_load | input | 1 | Coefficient row write enable |
| k_row | input | 2 | Row to write: 0, 1, 2; 3 is ignored |
| ka | input | 10 | Coefficient applied to a, signed Q0.9 |
| kb | input | 10 | Coefficient applied to b, signed Q0.9 |
| kc | input | 10 | Coefficient applied to c, signed Q0.9 |
| out_valid | output | 1 | Marks x, y, z as a valid result |
| x | output | 12 | Row 0 dot product, rounded |
| y | output | 12 | Row 1 dot product, rounded |
| z | output | 12 | Row 2 dot product, rounded |

## Verification
A corrupted coefficient register shows up on exactly one output lane, in the first result whose sample was captured after the write. That is four edges later, and the error persists until the row is rewritten. Wrong row decoding or a swapped ka/kb/kc column shows up as a mismatch on the wrong lane or for the wrong input, which is why the stimulus uses a different value per component. A slip in pipeline alignment between coefficients and samples is caught by writing rows in the middle of a stream and checking the exact sample on which the new weights start to apply.

// File: rtl/mm3_pkg.sv
package mm3_pkg;
   // number of sample components, output lanes and matrix rows
   localparam int MM_LANES       = 3;
   localparam int MM_ROW_W       = $clog2(MM_LANES + 1);
   // registers inside one lane: product, sum, rounded result
   localparam int MM_LANE_STAGES = 3;
   // input capture plus lane stages
   localparam int MM_LATENCY     = 1 + MM_LANE_STAGES;
endpackage

// File: rtl/mm3_coef_bank.sv
module mm3_coef_bank
   import mm3_pkg::*;
#(
   parameter int COEF_W = 10
)(
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        wr_en,
   input  logic [MM_ROW_W-1:0]                         wr_row,
   input  logic [MM_LANES-1:0][COEF_W-1:0]             wr_word,
   output logic [MM_LANES-1:0][MM_LANES-1:0][COEF_W-1:0] coef
);

   if (COEF_W < 2) begin : g_bad_coef_w
      $error("mm3_coef_bank: COEF_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef <= '0;
      end else begin
         for (int r = 0; r < MM_LANES; r++) begin
            if (wr_en && (wr_row == MM_ROW_W'(r))) begin
               coef[r] <= wr_word;
            end
         end
      end
   end

   // R7
   row_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_row >= MM_ROW_W'(MM_LANES))) |=> $stable(coef));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(coef));

endmodule

// File: rtl/mm3_dot_lane.sv
module mm3_dot_lane
   import mm3_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int COEF_W   = 10,
   parameter int FRAC_W   = COEF_W - 1,
   parameter bit ROUND_EN = 1'b1
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [MM_LANES-1:0][DATA_W-1:0]   smp,
   input  logic [MM_LANES-1:0][COEF_W-1:0]   kvec,
   output logic [DATA_W-1:0]                 result
);

   localparam int PROD_W = DATA_W + COEF_W;
   localparam int SUM_W  = PROD_W + $clog2(MM_LANES);
   localparam int RND_W  = SUM_W + 1;
   localparam logic [RND_W-1:0] HALF_LSB = RND_W'(1) << (FRAC_W - 1);

   if (FRAC_W < 1 || FRAC_W >= COEF_W) begin : g_bad_frac
      $error("mm3_dot_lane: FRAC_W must lie in 1..COEF_W-1");
   end
   if (RND_W < FRAC_W + DATA_W) begin : g_bad_range
      $error("mm3_dot_lane: sum too narrow for output slice");
   end

   logic signed [PROD_W-1:0] prod_q [MM_LANES];
   logic signed [SUM_W-1:0]  sum_d;
   logic signed [SUM_W-1:0]  sum_q;
   logic signed [RND_W-1:0]  rnd_w;

   // stage 1: nine-way parallel multiply, one per component here
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MM_LANES; i++) prod_q[i] <= '0;
      end else begin
         for (int i = 0; i < MM_LANES; i++) begin
            prod_q[i] <= $signed({{COEF_W{smp[i][DATA_W-1]}}, smp[i]})
                       * $signed({{DATA_W{kvec[i][COEF_W-1]}}, kvec[i]});
         end
      end
   end

   // stage 2: full-precision sum
   always_comb begin
      sum_d = '0;
      for (int i = 0; i < MM_LANES; i++) begin
         sum_d = sum_d + SUM_W'(prod_q[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_d;
   end

   // stage 3: rounding variant chosen at elaboration
   if (ROUND_EN) begin : g_round_half_up
      assign rnd_w = RND_W'(sum_q) + HALF_LSB;
   end else begin : g_truncate
      assign rnd_w = RND_W'(sum_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= rnd_w[FRAC_W +: DATA_W];
   end

   logic unused_rnd_bits;
   assign unused_rnd_bits = ^{rnd_w[RND_W-1:FRAC_W+DATA_W], rnd_w[FRAC_W-1:0]};

   logic prod_zero;
   always_comb begin
      prod_zero = 1'b1;
      for (int i = 0; i < MM_LANES; i++) begin
         if (prod_q[i] != '0) prod_zero = 1'b0;
      end
   end

   // R4
   zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prod_zero |=> ##1 (result == '0));

endmodule

// File: rtl/mm3_valid_pipe.sv
module mm3_valid_pipe #(
   parameter int DEPTH = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic vin,
   output logic vout
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mm3_valid_pipe: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[DEPTH-2:0], vin};
   end

   assign vout = stage_q[DEPTH-1];

endmodule

// File: rtl/matmul3x3.sv
module matmul3x3
   import mm3_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int COEF_W   = 10,
   parameter bit ROUND_EN = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  logic [DATA_W-1:0]   c,
   input  logic                k_load,
   input  logic [MM_ROW_W-1:0] k_row,
   input  logic [COEF_W-1:0]   ka,
   input  logic [COEF_W-1:0]   kb,
   input  logic [COEF_W-1:0]   kc,
   output logic                out_valid,
   output logic [DATA_W-1:0]   x,
   output logic [DATA_W-1:0]   y,
   output logic [DATA_W-1:0]   z
);

   localparam int FRAC_W = COEF_W - 1;
   localparam int WARM_W = $clog2(MM_LATENCY + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("matmul3x3: DATA_W must be at least 2");
   end
   if (MM_LANES != 3) begin : g_bad_lanes
      $error("matmul3x3: port list is built for three lanes");
   end

   logic [MM_LANES-1:0][DATA_W-1:0]                smp_q;
   logic [MM_LANES-1:0][MM_LANES-1:0][COEF_W-1:0]  coef;
   logic [MM_LANES-1:0][DATA_W-1:0]                res;

   // registered sample capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= '0;
      else        smp_q <= {c, b, a};
   end

   mm3_coef_bank #(
      .COEF_W (COEF_W)
   ) u_coef (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (k_load),
      .wr_row  (k_row),
      .wr_word ({kc, kb, ka}),
      .coef    (coef)
   );

   for (genvar r = 0; r < MM_LANES; r++) begin : g_lane
      mm3_dot_lane #(
         .DATA_W   (DATA_W),
         .COEF_W   (COEF_W),
         .FRAC_W   (FRAC_W),
         .ROUND_EN (ROUND_EN)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .smp    (smp_q),
         .kvec   (coef[r]),
         .result (res[r])
      );
   end

   mm3_valid_pipe #(
      .DEPTH (MM_LATENCY)
   ) u_vld (
      .clk   (clk),
      .rst_n (rst_n),
      .vin   (in_valid),
      .vout  (out_valid)
   );

   assign x = res[0];
   assign y = res[1];
   assign z = res[2];

   // edges seen since reset, saturating; guards the latency window
   logic [WARM_W-1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              warm_q <= '0;
      else if (warm_q != WARM_W'(MM_LATENCY))  warm_q <= warm_q + 1'b1;
   end

   // R8
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == WARM_W'(MM_LATENCY)) |-> (out_valid == $past(in_valid, MM_LATENCY)));

   // R1
   reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == '0) |-> (!out_valid && x == '0 && y == '0 && z == '0));

endmodule

// File: tb/matmul3x3_test.sv
module matmul3x3_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] a = '0, b = '0, c = '0;
   logic        k_load = 1'b0;
   logic [1:0]  k_row = '0;
   logic [9:0]  ka = '0, kb = '0, kc = '0;
   logic        out_valid;
   logic [11:0] x, y, z;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   int km [3][3];
   int km_next [3][3];
   int exq [3][32];

   always #10 clk = ~clk;

   matmul3x3 uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a(a), .b(b), .c(c),
      .k_load(k_load), .k_row(k_row), .ka(ka), .kb(kb), .kc(kc),
      .out_valid(out_valid), .x(x), .y(y), .z(z)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model(input int r, input int av, input int bv, input int cv);
      int s;
      s = km[r][0] * av + km[r][1] * bv + km[r][2] * cv;
      s = (s + 256) >>> 9;
      return s & 4095;
   endfunction

   function automatic int gen(input int i, input int lane, input int seed);
      return ((i * 1237 + lane * 389 + seed * 71) % 4096) - 2048;
   endfunction

   task automatic load_matrix(input int m [3][3]);
      for (int r = 0; r < 3; r++) begin
         @(negedge clk);
         k_load = 1'b1; k_row = 2'(r);
         ka = 10'(m[r][0]); kb = 10'(m[r][1]); kc = 10'(m[r][2]);
         for (int col = 0; col < 3; col++) km[r][col] = m[r][col];
      end
      @(negedge clk);
      k_load = 1'b0;
   endtask

   // drives n samples back-to-back; rows of km_next load at ld_at..ld_at+2
   task automatic stream(input string tag, input int n, input int seed, input int ld_at);
      for (int i = 0; i <= n + 4; i++) begin
         @(negedge clk);
         if (i >= 4 && i - 4 < n) begin
            chk({tag, " R8 R9 out_valid"}, int'(out_valid), 1);
            chk({tag, " R2 x"}, int'(x), exq[0][i-4]);
            chk({tag, " R2 y"}, int'(y), exq[1][i-4]);
            chk({tag, " R2 z"}, int'(z), exq[2][i-4]);
         end
         if (i == n + 4) chk({tag, " R9 out_valid low"}, int'(out_valid), 0);
         if (i < n) begin
            int av, bv, cv;
            if (ld_at >= 0 && i >= ld_at && i < ld_at + 3) begin
               int r;
               r = i - ld_at;
               k_load = 1'b1; k_row = 2'(r);
               ka = 10'(km_next[r][0]); kb = 10'(km_next[r][1]); kc = 10'(km_next[r][2]);
               for (int col = 0; col < 3; col++) km[r][col] = km_next[r][col];
            end else begin
               k_load = 1'b0;
            end
            av = gen(i, 0, seed); bv = gen(i, 1, seed); cv = gen(i, 2, seed);
            a = 12'(av); b = 12'(bv); c = 12'(cv);
            in_valid = 1'b1;
            for (int r = 0; r < 3; r++) exq[r][i] = model(r, av, bv, cv);
         end else begin
            in_valid = 1'b0;
            k_load = 1'b0;
         end
      end
   endtask

   task automatic single(input string tag, input int av, input int bv, input int cv,
                         input int ex, input int ey, input int ez);
      @(negedge clk);
      a = 12'(av); b = 12'(bv); c = 12'(cv); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk({tag, " R8 out_valid"}, int'(out_valid), 1);
      chk({tag, " x"}, int'(x), ex & 4095);
      chk({tag, " y"}, int'(y), ey & 4095);
      chk({tag, " z"}, int'(z), ez & 4095);
   endtask

   task automatic t_reset();
      chk("R1 out_valid in reset", int'(out_valid), 0);
      chk("R1 x in reset", int'(x), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      chk("R1 y after reset", int'(y), 0);
      chk("R1 z after reset", int'(z), 0);
      for (int r = 0; r < 3; r++)
         for (int col = 0; col < 3; col++) km[r][col] = 0;
      stream("R1 zero coefs", 3, 5, -1);
   endtask

   task automatic t_matrix();
      int m [3][3];
      m = '{'{153, 301, 58}, '{-75, -147, 222}, '{315, -264, -51}};
      load_matrix(m);
      stream("R3 R6 colour matrix", 10, 11, -1);
      m = '{'{256, 0, 0}, '{0, 256, 0}, '{0, 0, 256}};
      load_matrix(m);
      stream("R2 half diagonal", 5, 3, -1);
   endtask

   task automatic t_round();
      int m [3][3];
      m = '{'{256, 0, 0}, '{255, 0, 0}, '{-256, 0, 0}};
      load_matrix(m);
      single("R4 a=1",   1, 0, 0, 1, 0, 0);
      single("R4 a=-1", -1, 0, 0, 0, 0, 1);
      single("R4 a=3",   3, 0, 0, 2, 1, -1);
   endtask

   task automatic t_wrap();
      int m [3][3];
      m = '{'{511, 511, 511}, '{511, 511, 511}, '{0, 0, 0}};
      load_matrix(m);
      single("R5 positive wrap",  2047,  2047,  2047, 2033, 2033, 0);
      single("R5 negative wrap", -2048, -2048, -2048, 2060, 2060, 0);
   endtask

   task automatic t_ignore();
      int m [3][3];
      m = '{'{-300, 120, 45}, '{90, -511, 200}, '{17, 33, -400}};
      load_matrix(m);
      @(negedge clk);
      k_load = 1'b1; k_row = 2'd3; ka = 10'h3FF; kb = 10'h155; kc = 10'h2AA;
      @(negedge clk);
      k_load = 1'b0; k_row = 2'd0; ka = 10'd123; kb = 10'd77; kc = 10'd9;
      @(negedge clk);
      stream("R7 ignored writes", 4, 19, -1);
   endtask

   task automatic t_midload();
      km_next = '{'{-511, 100, 0}, '{7, -300, 511}, '{256, 256, -256}};
      stream("R6 R10 mid-stream load", 12, 23, 4);
   endtask

   initial begin
      t_reset();
      t_matrix();
      t_round();
      t_wrap();
      t_ignore();
      t_midload();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule